// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block turns a 32-bit x86-style ModR/M addressing byte, together with any displacement bytes that follow it in the instruction byte stream, into a memory effective address. It pulls bytes from a valid/ready stream one at a time. It reads the base register through a combinational read port of an external eight-entry, 32-bit register file. When the address is ready, it raises a one-cycle completion strobe.

The byte is split into three fields. The mode field `mod` sits in bits 7:6. The register/opcode field sits in bits 5:3, and the register-or-memory field `rm` sits in bits 2:0. The mode decides how many displacement bytes follow (none, one or four) and whether a base register is used. Mode 3 names a register operand rather than memory. Scaled-index forms (rm = 4 with mod below 3) are not supported; they are flagged and complete without an address. The result stays on the outputs until the next instruction completes. An instruction decoder uses the reg field and the address to finish building a memory access.

Top module: `modrm_ea_unit`

## Requirements
- R1: `reg_idx` equals bits 5:3 and `rm_idx` equals bits 2:0 of the accepted ModR/M byte; `rf_idx` selects the register numbered by the rm field (0..7).
- R2: With mod = 0 and rm not 4 or 5, no displacement byte is consumed and `ea_addr` equals the value of register rm.
- R3: With mod = 0 and rm = 5, the next four accepted bytes form a little-endian 32-bit absolute address (first byte least significant) and no register value contributes.
- R4: With mod = 1, one displacement byte follows. It is sign-extended and added to register rm modulo 2^32 (for example, base 0x2001 with byte 0xff gives 0x2000). The add also happens when the base is zero.
- R5: With mod = 2, four little-endian displacement bytes follow and are added to register rm modulo 2^32 (0xffffffff acts as -1).
- R6: With mod = 3, `is_reg` is 1, `ea_addr` is 0, `rm_idx` names the register, and no displacement byte is consumed.
- R7: With rm = 4 and mod below 3, `unsup` is 1, `is_reg` is 0, `ea_addr` is 0, and no displacement byte is consumed.
- R8: `done` is high for exactly the one cycle after the last byte of an instruction is accepted (the ModR/M byte when nothing follows), and `in_ready` is low in that cycle.
- R9: A byte offered while `in_valid` is low is not consumed.
- R10: After reset, `done`, `is_reg`, `unsup`, `ea_addr`, `reg_idx` and `rm_idx` are 0, and `in_ready` is 1.
- R11: `ea_addr`, `is_reg` and `unsup` hold their values from one completion until the next ModR/M byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Instruction stream byte |
| in_valid | input | 1 | `in_byte` carries a byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| rf_idx | output | 3 | Register file read index (base register) |
| rf_data | input | 32 | Register file read data for `rf_idx`, combinational |
| ea_addr | output | 32 | Effective address result |
| reg_idx | output | 3 | Reg/opcode field of the ModR/M byte |
| rm_idx | output | 3 | Rm field of the ModR/M byte |
| is_reg | output | 1 | Operand is a register (mod = 3) |
| unsup | output | 1 | Unsupported addressing form (rm = 4, mod below 3) |
| done | output | 1 | One-cycle completion strobe |

## Verification
A wrong displacement byte count shows within one byte time. Too few bytes and `done` rises in the middle of the instruction. Too many and `done` never rises, and the following ModR/M byte gets swallowed as displacement, which breaks the next vector too. A wrong byte lane or a missing sign extension appears as a wrong `ea_addr` on the completion cycle itself. The bench sweeps all 256 ModR/M values twice, using varied displacements, stall gaps and register contents that include zero and values near the wrap point, so a mode or lane error is caught in the first few vectors that reach it.

// File: rtl/ea_pkg.sv
// Package: shared widths, decode record and sequencing states for the
// effective address generator. Assumes a byte-wide stream and a 32-bit word.
package ea_pkg;
    localparam int ADDR_W     = 32;
    localparam int RIDX_W     = 3;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = ADDR_W / BYTE_W;
    localparam int NBYTE_W    = $clog2(WORD_BYTES + 1);

    typedef enum logic [1:0] {
        DK_NONE = 2'd0,
        DK_BYTE = 2'd1,
        DK_WORD = 2'd2
    } disp_kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DISP = 2'd1,
        S_FIN  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [RIDX_W-1:0]  reg_f;
        logic [RIDX_W-1:0]  rm_f;
        logic               is_reg;
        logic               unsup;
        logic               absolute;
        disp_kind_t         kind;
        logic [NBYTE_W-1:0] nbytes;
    } modrm_info_t;
endpackage

// File: rtl/modrm_decode.sv
// Module: modrm_decode
// Purely combinational split of a ModR/M byte into fields plus the derived
// addressing class and trailing displacement byte count.
// Assumes: mod in bits 7:6, reg in 5:3, rm in 2:0.
module modrm_decode
    import ea_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm,
    output modrm_info_t       info
);
    logic [1:0] mode;
    assign mode = modrm[7:6];

    // Classify the addressing form and count the bytes that follow.
    always_comb begin
        info          = '0;
        info.reg_f    = modrm[5:3];
        info.rm_f     = modrm[2:0];
        info.is_reg   = (mode == 2'd3);
        info.unsup    = (mode != 2'd3) && (modrm[2:0] == 3'd4);
        info.absolute = (mode == 2'd0) && (modrm[2:0] == 3'd5);
        info.kind     = DK_NONE;
        info.nbytes   = '0;
        if (!info.is_reg && !info.unsup) begin
            if (info.absolute || mode == 2'd2) begin
                info.kind   = DK_WORD;
                info.nbytes = NBYTE_W'(WORD_BYTES);
            end else if (mode == 2'd1) begin
                info.kind   = DK_BYTE;
                info.nbytes = NBYTE_W'(1);
            end
        end
    end
endmodule

// File: rtl/disp_collect.sv
// Module: disp_collect
// Gathers little-endian displacement bytes into a word. disp_next shows the
// word with the byte on the input merged into its lane, so the final byte
// can be used in the same cycle it is accepted.
// Assumes: clr and take are never both high.
module disp_collect
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    localparam int NB = AW / BYTE_W,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [CW-1:0]     cnt,
    output logic [AW-1:0]     disp_next
);
    logic [AW-1:0] disp_q;

    // Merge the incoming byte into the lane selected by the byte counter.
    always_comb begin
        disp_next = disp_q;
        for (int k = 0; k < NB; k++) begin
            if (cnt == CW'(k)) disp_next[k*BYTE_W +: BYTE_W] = in_byte;
        end
    end

    // Advance the lane counter and store bytes; clear on a new instruction.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt    <= '0;
            disp_q <= '0;
        end else if (take) begin
            cnt    <= cnt + CW'(1);
            disp_q <= disp_next;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(NB)); // R5
endmodule

// File: rtl/ea_adder.sv
// Module: ea_adder
// Combinational address sum: base (or zero for absolute) plus a displacement
// that is sign-extended from one byte or taken as a full word; wraps mod 2^AW.
// Assumes: disp_word lanes above the first are ignored for DK_BYTE.
module ea_adder
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] disp_word,
    input  disp_kind_t    kind,
    input  logic          absolute,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] base_sel;
    logic [AW-1:0] disp_ext;

    // Pick the base and widen the displacement for the current mode.
    always_comb begin
        base_sel = absolute ? '0 : base;
        unique case (kind)
            DK_BYTE: disp_ext = {{(AW-BYTE_W){disp_word[BYTE_W-1]}}, disp_word[BYTE_W-1:0]};
            DK_WORD: disp_ext = disp_word;
            default: disp_ext = '0;
        endcase
        sum = base_sel + disp_ext;
    end
endmodule

// File: rtl/modrm_ea_unit.sv
// Module: modrm_ea_unit (top)
// Accepts a ModR/M byte and its displacement bytes from a valid/ready
// stream, reads the base register through rf_idx/rf_data, and registers the
// effective address with a one-cycle done strobe. Input is blocked during
// the done cycle. Assumes rf_data is a combinational read of rf_idx; the
// base is sampled on the cycle the final byte is accepted.
module modrm_ea_unit
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [RIDX_W-1:0] rf_idx,
    input  logic [ADDR_W-1:0] rf_data,
    output logic [ADDR_W-1:0] ea_addr,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [RIDX_W-1:0] rm_idx,
    output logic              is_reg,
    output logic              unsup,
    output logic              done
);
    localparam int CW = $clog2(WORD_BYTES + 1);

    seq_state_t    state;
    modrm_info_t   dec_now, info_q, cur;
    logic          take, take_mod, take_disp, last;
    logic [CW-1:0] cnt;
    logic [ADDR_W-1:0] disp_next, sum, addr_d;

    modrm_decode u_dec (.modrm(in_byte), .info(dec_now));

    // Decode seen live while idle, latched copy while collecting bytes.
    assign cur       = (state == S_IDLE) ? dec_now : info_q;
    assign in_ready  = (state != S_FIN);
    assign take      = in_valid && in_ready;
    assign take_mod  = take && (state == S_IDLE);
    assign take_disp = take && (state == S_DISP);
    assign rf_idx    = cur.rm_f;

    // Final byte of the instruction is being accepted this cycle.
    assign last = (take_mod && dec_now.nbytes == '0) ||
                  (take_disp && cnt == CW'(info_q.nbytes) - CW'(1));

    disp_collect #(.AW(ADDR_W)) u_disp (
        .clk(clk), .rst_n(rst_n), .clr(take_mod), .take(take_disp),
        .in_byte(in_byte), .cnt(cnt), .disp_next(disp_next)
    );

    ea_adder #(.AW(ADDR_W)) u_add (
        .base(rf_data),
        .disp_word(take_disp ? disp_next : '0),
        .kind(cur.kind), .absolute(cur.absolute), .sum(sum)
    );

    // Register operands and unsupported forms produce no address.
    assign addr_d = (cur.is_reg || cur.unsup) ? '0 : sum;

    // Sequence: idle -> (displacement bytes) -> done cycle -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (take) state <= last ? S_FIN : S_DISP;
                S_DISP:  if (last) state <= S_FIN;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Latch the decoded fields when the ModR/M byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        info_q <= '0;
        else if (take_mod) info_q <= dec_now;
    end

    // Register the result and raise the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_addr <= '0;
            is_reg  <= 1'b0;
            unsup   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                ea_addr <= addr_d;
                is_reg  <= cur.is_reg;
                unsup   <= cur.unsup;
            end
        end
    end

    assign reg_idx = info_q.reg_f;
    assign rm_idx  = info_q.rm_f;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_MODE3_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && state == S_IDLE && in_byte[7:6] == 2'b11) |=> (done && is_reg)); // R6
    AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_reg) |-> (ea_addr == '0 && !unsup)); // R6
    AST_UNSUP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unsup) |-> (ea_addr == '0 && !is_reg)); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ea_addr)); // R11
endmodule

// File: tb/modrm_ea_unit_tb_top.sv
// Bench: sweeps every ModR/M value with varied displacements and stalls,
// plus hand-picked wrap and sign corners; expected addresses computed here.
`timescale 1ns/1ps
module modrm_ea_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  rf_idx;
    logic [31:0] rf_data;
    logic [31:0] ea_addr;
    logic [2:0]  reg_idx, rm_idx;
    logic        is_reg, unsup, done;

    logic [31:0] rf [8];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;
    assign rf_data = rf[rf_idx];

    modrm_ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .in_ready(in_ready), .rf_idx(rf_idx), .rf_data(rf_data),
        .ea_addr(ea_addr), .reg_idx(reg_idx), .rm_idx(rm_idx),
        .is_reg(is_reg), .unsup(unsup), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one byte after `gap` idle cycles carrying junk (R9), at a negedge.
    task automatic feed(input logic [7:0] b, input int gap);
        for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0;
            in_byte  = ~b;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_instr(input logic [7:0] m, input logic [31:0] d, input int gap);
        logic [1:0] md = m[7:6];
        logic [2:0] rm = m[2:0];
        int n;
        logic [31:0] exp;
        string tag;
        if (md == 2'd3) begin n = 0; exp = 0; tag = "R6"; end
        else if (rm == 3'd4) begin n = 0; exp = 0; tag = "R7"; end
        else if (md == 2'd0 && rm == 3'd5) begin n = 4; exp = d; tag = "R3"; end
        else if (md == 2'd0) begin n = 0; exp = rf[rm]; tag = "R2"; end
        else if (md == 2'd1) begin n = 1; exp = rf[rm] + {{24{d[7]}}, d[7:0]}; tag = "R4"; end
        else begin n = 4; exp = rf[rm] + d; tag = "R5"; end

        feed(m, gap);
        for (int i = 0; i < n; i++) begin
            chk("R8 done early", {31'b0, done}, 32'd0);
            feed(d[i*8 +: 8], (i == 1) ? gap : 0);
        end
        chk("R8 done after last byte", {31'b0, done}, 32'd1);
        chk("R8 ready low in done cycle", {31'b0, in_ready}, 32'd0);
        chk(tag, ea_addr, exp);
        chk("R6 is_reg", {31'b0, is_reg}, {31'b0, md == 2'd3});
        chk("R7 unsup", {31'b0, unsup}, {31'b0, (md != 2'd3) && (rm == 3'd4)});
        chk("R1 reg field", {29'b0, reg_idx}, {29'b0, m[5:3]});
        chk("R1 rm field", {29'b0, rm_idx}, {29'b0, rm});
        @(negedge clk);
        chk("R8 done one cycle", {31'b0, done}, 32'd0);
        chk("R11 address held", ea_addr, exp);
        chk("R9 ready back", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    initial begin
        rf[0] = 32'h0000_0000; rf[1] = 32'h0000_2001;
        rf[2] = 32'h0000_1ffe; rf[3] = 32'hffff_ff80;
        rf[4] = 32'hdead_beef; rf[5] = 32'h7fff_ffff;
        rf[6] = 32'h1234_5678; rf[7] = 32'hffff_fffe;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 done", {31'b0, done}, 32'd0);
        chk("R10 ready", {31'b0, in_ready}, 32'd1);
        chk("R10 addr", ea_addr, 32'd0);
        chk("R10 flags", {30'b0, is_reg, unsup}, 32'd0);
        chk("R10 fields", {26'b0, reg_idx, rm_idx}, 32'd0);

        // Corners: negative byte and word displacements, absolute, zero base, wrap.
        do_instr(8'h41, 32'h0000_00ff, 0);  // R4 0x2001 + (-1)
        do_instr(8'h81, 32'hffff_ffff, 0);  // R5 0x2001 + (-1)
        do_instr(8'h1d, 32'h0000_2000, 1);  // R3 absolute
        do_instr(8'h40, 32'h0000_0010, 0);  // R4 zero base still adds
        do_instr(8'h87, 32'h0000_0005, 2);  // R5 wrap to 0x3
        do_instr(8'h43, 32'h0000_0080, 0);  // R4 0xffffff80 + (-128)
        do_instr(8'hd8, 32'h0000_0000, 0);  // R6 register operand
        do_instr(8'h24, 32'h0000_0000, 0);  // R7 unsupported, next byte is new ModR/M
        do_instr(8'h06, 32'h0000_0000, 3);  // R2 plain base

        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) begin
                logic [31:0] d = 32'h9e37_79b9 * (i + 1 + pass * 256) ^ (pass ? 32'h8000_0080 : 32'h0);
                do_instr(8'(i), d, (i % 5 == 0) ? 2 : ((i % 3 == 0) ? 1 : 0));
            end
        end
        summary();
    end
endmodule